// File: doc/BRIEF.md
# Multicore Barrier and Bus Controller

This block is the control hub of a small shared-memory multiprocessor built with one, two or four cores. Core 0 is the main core. The block owns the single external memory port and hands it to one core at a time using fixed priority. While a core holds the grant, the block steers that core's address, write data and write strobe onto the memory port through select-driven multiplexers. It also returns the memory acknowledge to that core alone.

It also provides two synchronization primitives. After reset only the main core runs. When the main core issues a start-parallel request (`unroll`), the block releases every worker core together with a one-cycle start pulse. Each core that reaches a barrier raises its barrier line once and then stalls. When every configured core has arrived, the block raises `main_sync` for one cycle. This lets the main core resume, halts the workers, and clears the barrier collection so that the next parallel region starts cleanly.

The arbiter state machine has two states. ARB_IDLE picks the lowest-index requester and moves to ARB_BUSY (transition "grant"). ARB_BUSY returns to ARB_IDLE on the memory acknowledge (transition "complete"). The region state machine moves from RG_SERIAL to RG_PARALLEL on an unroll (transition "release"), and back to RG_SERIAL when a barrier completes (transition "join"). The barrier state machine moves from BR_COLLECT to BR_RELEASE once all lines have been seen (transition "all arrived"), and returns to BR_COLLECT one cycle later (transition "rearm").

Top module: `mcb_ctrl`

## Requirements
- R1: When the arbiter is idle and one or more `core_req` bits are set, the lowest-index requesting core wins. In the next cycle `mem_req` is 1 and `mux_sel` holds the winner's index (core 0 = index 0).
- R2: The grant is held, with `mux_sel` unchanged, until `mem_ack` is seen, even if a higher-priority request appears. While granted, `mem_addr`, `mem_wdata` and `mem_we` carry the granted core's slice of `core_addr`, `core_wdata` and `core_we` (core i at bits i*width upward). `core_ack` is one-hot on the granted core in the same cycle as `mem_ack`.
- R3: In the cycle after an acknowledged cycle, `mem_req` is 0. The next grant is decided in that cycle.
- R4: After reset, `core_run` equals 1 (only bit 0, the main core, set), `core_start`, `main_sync` and `mem_req` are 0, and the worker bits of `core_run` stay 0 for as long as no unroll is issued.
- R5: An `unroll` seen in the serial region makes `core_start` equal to all worker bits (bit 0 clear) for exactly the next cycle, and sets every worker bit of `core_run`. An `unroll` seen while the parallel region is already running produces no start pulse.
- R6: `main_sync` rises in the cycle after the cycle in which the last missing barrier line is seen. It is never high before that, and it is high for one cycle. A one-cycle barrier pulse is remembered until the round completes.
- R7: In the cycle `main_sync` is high, the worker bits of `core_run` are 0 and all arrivals are cleared. A later round needs every core to arrive again.
- R8: With one configured core, a barrier line completes the barrier on the next cycle, and `core_start` stays 0 on an unroll.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| core_req | input | N_CORES | Per-core memory request, held until acknowledged |
| core_we | input | N_CORES | Per-core write strobe |
| core_addr | input | N_CORES*ADDR_W | Per-core address, core i in slice i |
| core_wdata | input | N_CORES*DATA_W | Per-core write data, core i in slice i |
| core_ack | output | N_CORES | Acknowledge returned to the granted core |
| mem_req | output | 1 | External memory request |
| mem_we | output | 1 | External write strobe (granted core) |
| mem_addr | output | ADDR_W | External address (granted core) |
| mem_wdata | output | DATA_W | External write data (granted core) |
| mem_ack | input | 1 | External memory acknowledge |
| mux_sel | output | SEL_W | Select driving the address and data multiplexers |
| unroll | input | 1 | Start-parallel request from the main core |
| core_barr | input | N_CORES | Per-core barrier arrival line |
| core_start | output | N_CORES | One-cycle start pulse to each worker core |
| core_run | output | N_CORES | Per-core run enable |
| main_sync | output | 1 | Barrier complete, main core resumes |

## Verification
The bench builds two instances. The first has four cores, which exposes every priority ordering, the hold of a grant against a later higher-priority request, random barrier arrival orders, and stale-arrival clearing between rounds. The second has a single core, which brings within reach the degenerate cases: a barrier that completes on the next cycle and an unroll that has no worker to start. Requests are drawn from a fixed-seed random source with random memory latency, alongside directed corner cases.

// File: rtl/mcb_pkg.sv
`timescale 1ns/1ps
package mcb_pkg;
    typedef enum logic {ARB_IDLE, ARB_BUSY} arb_state_t;
    typedef enum logic {RG_SERIAL, RG_PARALLEL} region_state_t;
    typedef enum logic {BR_COLLECT, BR_RELEASE} barr_state_t;

    function automatic int sel_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/mcb_arbiter.sv
`timescale 1ns/1ps
module mcb_arbiter
    import mcb_pkg::*;
#(
    parameter int N_CORES = 4,
    parameter int SEL_W   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_CORES-1:0] req,
    input  logic               mem_ack,
    output logic               busy,
    output logic [SEL_W-1:0]   sel,
    output logic [N_CORES-1:0] ack
);
    arb_state_t       state_q, state_d;
    logic [SEL_W-1:0] pick;
    logic [SEL_W-1:0] sel_q;
    logic             any_req;

    // Fixed priority: scanning downward leaves the lowest index set.
    always_comb begin
        pick = '0;
        for (int i = N_CORES - 1; i >= 0; i--) begin
            if (req[i]) pick = SEL_W'(i);
        end
    end

    assign any_req = |req;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ARB_IDLE: if (any_req) state_d = ARB_BUSY;
            ARB_BUSY: if (mem_ack) state_d = ARB_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ARB_IDLE;
            sel_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ARB_IDLE && any_req) sel_q <= pick;
        end
    end

    always_comb begin
        busy = (state_q == ARB_BUSY);
        sel  = sel_q;
        for (int i = 0; i < N_CORES; i++) begin
            ack[i] = busy && mem_ack && (sel_q == SEL_W'(i));
        end
    end
endmodule

// File: rtl/mcb_sync_ctrl.sv
`timescale 1ns/1ps
module mcb_sync_ctrl
    import mcb_pkg::*;
#(
    parameter int N_CORES = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               unroll,
    input  logic [N_CORES-1:0] barr,
    output logic [N_CORES-1:0] start,
    output logic [N_CORES-1:0] run,
    output logic               sync
);
    localparam logic [N_CORES-1:0] MAIN_BIT    = N_CORES'(1);
    localparam logic [N_CORES-1:0] WORKER_MASK = ~MAIN_BIT;

    region_state_t      region_q, region_d;
    barr_state_t        bstate_q, bstate_d;
    logic [N_CORES-1:0] arrived_q;
    logic [N_CORES-1:0] start_q;
    logic               all_in;
    logic               do_release;

    assign all_in     = &(arrived_q | barr);
    assign do_release = (region_q == RG_SERIAL) && unroll;

    always_comb begin
        bstate_d = bstate_q;
        unique case (bstate_q)
            BR_COLLECT: if (all_in) bstate_d = BR_RELEASE;
            BR_RELEASE: bstate_d = BR_COLLECT;
        endcase
    end

    always_comb begin
        region_d = region_q;
        unique case (region_q)
            RG_SERIAL:   if (unroll) region_d = RG_PARALLEL;
            RG_PARALLEL: if (bstate_q == BR_COLLECT && all_in) region_d = RG_SERIAL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            region_q  <= RG_SERIAL;
            bstate_q  <= BR_COLLECT;
            arrived_q <= '0;
            start_q   <= '0;
        end else begin
            region_q <= region_d;
            bstate_q <= bstate_d;
            start_q  <= do_release ? WORKER_MASK : '0;
            if (bstate_q == BR_COLLECT && !all_in) arrived_q <= arrived_q | barr;
            else                                   arrived_q <= '0;
        end
    end

    always_comb begin
        start = start_q;
        run   = (region_q == RG_PARALLEL) ? (WORKER_MASK | MAIN_BIT) : MAIN_BIT;
        sync  = (bstate_q == BR_RELEASE);
    end
endmodule

// File: rtl/mcb_ctrl.sv
`timescale 1ns/1ps
module mcb_ctrl
    import mcb_pkg::*;
#(
    parameter int  N_CORES = 4,
    parameter int  ADDR_W  = 16,
    parameter int  DATA_W  = 32,
    localparam int SEL_W   = sel_width(N_CORES)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N_CORES-1:0]        core_req,
    input  logic [N_CORES-1:0]        core_we,
    input  logic [N_CORES*ADDR_W-1:0] core_addr,
    input  logic [N_CORES*DATA_W-1:0] core_wdata,
    output logic [N_CORES-1:0]        core_ack,
    output logic                      mem_req,
    output logic                      mem_we,
    output logic [ADDR_W-1:0]         mem_addr,
    output logic [DATA_W-1:0]         mem_wdata,
    input  logic                      mem_ack,
    output logic [SEL_W-1:0]          mux_sel,
    input  logic                      unroll,
    input  logic [N_CORES-1:0]        core_barr,
    output logic [N_CORES-1:0]        core_start,
    output logic [N_CORES-1:0]        core_run,
    output logic                      main_sync
);
    logic busy;

    mcb_arbiter #(.N_CORES(N_CORES), .SEL_W(SEL_W)) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (core_req),
        .mem_ack (mem_ack),
        .busy    (busy),
        .sel     (mux_sel),
        .ack     (core_ack)
    );

    mcb_sync_ctrl #(.N_CORES(N_CORES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .unroll (unroll),
        .barr   (core_barr),
        .start  (core_start),
        .run    (core_run),
        .sync   (main_sync)
    );

    // Address and data multiplexers steered by the grant select.
    always_comb begin
        mem_req   = busy;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        for (int i = 0; i < N_CORES; i++) begin
            if (busy && mux_sel == SEL_W'(i)) begin
                mem_we    = core_we[i];
                mem_addr  = core_addr[i*ADDR_W +: ADDR_W];
                mem_wdata = core_wdata[i*DATA_W +: DATA_W];
            end
        end
    end
endmodule

// File: rtl/mcb_ctrl_chk.sv
`timescale 1ns/1ps
module mcb_ctrl_chk
    import mcb_pkg::*;
#(
    parameter int  N_CORES = 4,
    localparam int SEL_W   = sel_width(N_CORES)
) (
    input logic               clk,
    input logic               rst_n,
    input logic [N_CORES-1:0] core_req,
    input logic [N_CORES-1:0] core_ack,
    input logic               mem_req,
    input logic               mem_ack,
    input logic [SEL_W-1:0]   mux_sel,
    input logic               unroll,
    input logic [N_CORES-1:0] core_barr,
    input logic [N_CORES-1:0] core_start,
    input logic [N_CORES-1:0] core_run,
    input logic               main_sync
);
    logic [N_CORES-1:0] seen_q;

    function automatic logic [N_CORES-1:0] below(input logic [SEL_W-1:0] s);
        logic [N_CORES-1:0] m;
        for (int i = 0; i < N_CORES; i++) m[i] = (i < int'(s));
        return m;
    endfunction

    // Independent arrival record for the sync check.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         seen_q <= '0;
        else if (main_sync) seen_q <= '0;
        else                seen_q <= seen_q | core_barr;
    end

    p_prio_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req) |-> (($past(core_req) & below(mux_sel)) == '0));

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mux_sel)));

    p_ack_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(core_ack) && ((core_ack == '0) || (mem_req && mem_ack)));

    p_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack) |=> !mem_req);

    p_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (core_start != '0) |-> $past(unroll));

    p_main_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !core_start[0]);

    p_sync_late_r6: assert property (@(posedge clk) disable iff (!rst_n)
        main_sync |-> (&seen_q));

    p_sync_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        main_sync |=> !main_sync);

    p_halt_r7: assert property (@(posedge clk) disable iff (!rst_n)
        main_sync |-> (core_run == N_CORES'(1)));

    if (N_CORES > 1) begin : g_worker
        p_run_r4: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(core_run[N_CORES-1]) |-> $past(unroll));
    end
endmodule

bind mcb_ctrl mcb_ctrl_chk #(.N_CORES(N_CORES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .core_req   (core_req),
    .core_ack   (core_ack),
    .mem_req    (mem_req),
    .mem_ack    (mem_ack),
    .mux_sel    (mux_sel),
    .unroll     (unroll),
    .core_barr  (core_barr),
    .core_start (core_start),
    .core_run   (core_run),
    .main_sync  (main_sync)
);

// File: tb/mcb_ctrl_bench.sv
`timescale 1ns/1ps
module mcb_ctrl_bench;
    localparam int AW = 16;
    localparam int DW = 32;

    logic clk = 1'b0;
    always #10 clk = ~clk;
    logic rst_n;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // Four-core instance
    logic [3:0]      q_req, q_we, q_ack, q_barr, q_start, q_run;
    logic [4*AW-1:0] q_addr;
    logic [4*DW-1:0] q_wdata;
    logic            q_mreq, q_mwe, q_mack, q_unroll, q_sync;
    logic [AW-1:0]   q_maddr;
    logic [DW-1:0]   q_mwdata;
    logic [1:0]      q_sel;

    // Single-core instance
    logic [0:0]    s_req, s_we, s_ack, s_barr, s_start, s_run, s_sel;
    logic [AW-1:0] s_addr, s_maddr;
    logic [DW-1:0] s_wdata, s_mwdata;
    logic          s_mreq, s_mwe, s_mack, s_unroll, s_sync;

    mcb_ctrl #(.N_CORES(4), .ADDR_W(AW), .DATA_W(DW)) u_mcb_ctrl (
        .clk(clk), .rst_n(rst_n), .core_req(q_req), .core_we(q_we),
        .core_addr(q_addr), .core_wdata(q_wdata), .core_ack(q_ack),
        .mem_req(q_mreq), .mem_we(q_mwe), .mem_addr(q_maddr), .mem_wdata(q_mwdata),
        .mem_ack(q_mack), .mux_sel(q_sel), .unroll(q_unroll), .core_barr(q_barr),
        .core_start(q_start), .core_run(q_run), .main_sync(q_sync)
    );

    mcb_ctrl #(.N_CORES(1), .ADDR_W(AW), .DATA_W(DW)) u_mcb_ctrl_one (
        .clk(clk), .rst_n(rst_n), .core_req(s_req), .core_we(s_we),
        .core_addr(s_addr), .core_wdata(s_wdata), .core_ack(s_ack),
        .mem_req(s_mreq), .mem_we(s_mwe), .mem_addr(s_maddr), .mem_wdata(s_mwdata),
        .mem_ack(s_mack), .mux_sel(s_sel), .unroll(s_unroll), .core_barr(s_barr),
        .core_start(s_start), .core_run(s_run), .main_sync(s_sync)
    );

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic int lowest(input logic [3:0] r);
        for (int i = 0; i < 4; i++) if (r[i]) return i;
        return 0;
    endfunction

    // One memory transaction on the four-core instance; called at negedge+1.
    task automatic txn(input logic [3:0] r, input int lat, input bit late_hi);
        int w;
        w = lowest(r);
        for (int i = 0; i < 4; i++) begin
            q_addr[i*AW +: AW]  = AW'($urandom);
            q_wdata[i*DW +: DW] = $urandom;
            q_we[i]             = 1'($urandom);
        end
        q_req = r;
        @(negedge clk); #1;
        chk("R1", "grant index", 64'(q_sel), 64'(w));
        chk("R1", "mem_req raised", 64'(q_mreq), 64'd1);
        chk("R2", "address route", 64'(q_maddr), 64'(q_addr[w*AW +: AW]));
        chk("R2", "data route", 64'(q_mwdata), 64'(q_wdata[w*DW +: DW]));
        chk("R2", "write route", 64'(q_mwe), 64'(q_we[w]));
        for (int k = 0; k < lat; k++) begin
            if (late_hi) q_req = q_req | 4'b0001;
            @(negedge clk); #1;
            chk("R2", "grant held", 64'(q_sel), 64'(w));
            chk("R2", "request held", 64'(q_mreq), 64'd1);
        end
        q_mack = 1'b1; #1;
        chk("R2", "core ack one-hot", 64'(q_ack), 64'(4'b0001 << w));
        @(negedge clk);
        q_mack = 1'b0;
        q_req  = '0;
        #1;
        chk("R3", "idle gap after ack", 64'(q_mreq), 64'd0);
    endtask

    task automatic pulse_barr(input logic [3:0] b);
        q_barr = b;
        @(negedge clk);
        q_barr = '0;
        #1;
    endtask

    task automatic do_unroll();
        q_unroll = 1'b1;
        @(negedge clk);
        q_unroll = 1'b0;
        #1;
        chk("R5", "start pulse on workers", 64'(q_start), 64'hE);
        chk("R5", "workers running", 64'(q_run), 64'hF);
        @(negedge clk); #1;
        chk("R5", "start pulse one cycle", 64'(q_start), 64'h0);
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        rst_n = 1'b0;
        q_req = '0; q_we = '0; q_addr = '0; q_wdata = '0; q_mack = 1'b0;
        q_unroll = 1'b0; q_barr = '0;
        s_req = '0; s_we = '0; s_addr = '0; s_wdata = '0; s_mack = 1'b0;
        s_unroll = 1'b0; s_barr = '0;
        repeat (3) @(negedge clk);
        #1;
        chk("R4", "run in reset", 64'(q_run), 64'h1);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk("R4", "run after reset", 64'(q_run), 64'h1);
        chk("R4", "start after reset", 64'(q_start), 64'h0);
        chk("R4", "sync after reset", 64'(q_sync), 64'h0);
        chk("R4", "mem_req after reset", 64'(q_mreq), 64'h0);
        chk("R4", "single run after reset", 64'(s_run), 64'h1);

        // Directed arbitration corners
        txn(4'b1010, 2, 1'b1);
        txn(4'b1111, 0, 1'b0);
        txn(4'b1000, 1, 1'b0);
        txn(4'b0110, 3, 1'b1);
        repeat (3) begin
            @(negedge clk); #1;
            chk("R4", "workers halted without unroll", 64'(q_run), 64'h1);
        end

        // Constrained random arbitration
        for (int t = 0; t < 40; t++) begin
            txn(4'($urandom_range(1, 15)), $urandom_range(0, 3), 1'($urandom));
        end

        // Unroll, and a second unroll inside the parallel region
        do_unroll();
        q_unroll = 1'b1;
        @(negedge clk);
        q_unroll = 1'b0;
        #1;
        chk("R5", "unroll while parallel ignored", 64'(q_start), 64'h0);

        // Barrier rounds in random arrival order
        for (int rnd = 0; rnd < 6; rnd++) begin
            int ord [4];
            if (rnd > 0) do_unroll();
            for (int i = 0; i < 4; i++) ord[i] = i;
            for (int i = 3; i > 0; i--) begin
                int j;
                int tmp;
                j = $urandom_range(0, i);
                tmp = ord[i]; ord[i] = ord[j]; ord[j] = tmp;
            end
            for (int k = 0; k < 4; k++) begin
                pulse_barr(4'b0001 << ord[k]);
                if (k < 3) begin
                    chk("R6", "sync before last arrival", 64'(q_sync), 64'h0);
                    repeat ($urandom_range(0, 2)) begin
                        @(negedge clk); #1;
                        chk("R6", "sync while waiting", 64'(q_sync), 64'h0);
                    end
                end else begin
                    chk("R6", "sync after last arrival", 64'(q_sync), 64'h1);
                    chk("R7", "workers halted at sync", 64'(q_run), 64'h1);
                end
            end
            @(negedge clk); #1;
            chk("R6", "sync one cycle wide", 64'(q_sync), 64'h0);
            chk("R7", "workers stay halted", 64'(q_run), 64'h1);
        end

        // Arrivals from the previous round must not count
        do_unroll();
        pulse_barr(4'b1000);
        chk("R7", "stale arrivals cleared", 64'(q_sync), 64'h0);
        @(negedge clk); #1;
        chk("R7", "stale arrivals cleared later", 64'(q_sync), 64'h0);
        pulse_barr(4'b0111);
        chk("R6", "sync on simultaneous arrivals", 64'(q_sync), 64'h1);
        @(negedge clk); #1;

        // Single-core configuration
        s_unroll = 1'b1;
        @(negedge clk);
        s_unroll = 1'b0;
        #1;
        chk("R8", "single unroll no start", 64'(s_start), 64'h0);
        chk("R8", "single run", 64'(s_run), 64'h1);
        s_barr = 1'b1;
        @(negedge clk);
        s_barr = 1'b0;
        #1;
        chk("R8", "single barrier next cycle", 64'(s_sync), 64'h1);
        @(negedge clk); #1;
        chk("R8", "single sync one cycle", 64'(s_sync), 64'h0);
        s_barr = 1'b1;
        @(negedge clk);
        s_barr = 1'b0;
        #1;
        chk("R8", "single barrier in serial region", 64'(s_sync), 64'h1);
        s_addr = 16'hBEEF;
        s_req  = 1'b1;
        @(negedge clk); #1;
        chk("R1", "single grant", 64'(s_mreq), 64'h1);
        chk("R2", "single address route", 64'(s_maddr), 64'hBEEF);
        s_mack = 1'b1; #1;
        chk("R2", "single ack", 64'(s_ack), 64'h1);
        @(negedge clk);
        s_mack = 1'b0;
        s_req  = 1'b0;
        #1;
        chk("R3", "single idle gap", 64'(s_mreq), 64'h0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule